// File: doc/BRIEF.md
# Five-Channel PWM with Rate Multiplier

This block drives five output pins, each from its own 8-bit setting. The upper five bits of a setting give the width of a high pulse inside a 32-clock PWM cycle. The lower three bits, N, form a rate multiplier: in N of the 8 cycles of a frame, the high period is one PWM clock longer. Averaged over a frame, the duty cycle therefore has 256 distinct steps, while the repetition rate is set by the 32-clock cycle and not by a 256-clock one. A low-pass filter outside the chip turns each pin into a simple DAC.

All channels share one PWM clock enable, derived from the system clock by a power-of-two prescaler, and one cycle/frame counter, so every channel starts its frames together. A per-channel enable chooses whether a pin shows the waveform or the ordinary port latch value. Software reaches the settings through a small register bus. A new setting is held in a staging register and copied into the active set only at a frame boundary, so a write never produces a partial cycle.

Top module: `pwm5_brm`

## Requirements
- R1: After reset all five channel settings read 0x00, the prescale field reads 0, the enable field reads 0, and every pin equals its port latch input.
- R2: Register map on `addr`: 0 to 4 are the channel settings (8 bits, read back as written); 5 is the prescale field in bits 1:0; 6 is the enable field in bits 4:0 (bit i for channel i). Unused bits read 0; address 7 reads 0 and a write to it changes nothing.
- R3: The PWM clock runs at the system clock divided by 2^(S+1), S being the prescale field, so a frame lasts 256*2^(S+1) system clocks.
- R4: A cycle is 32 PWM clocks; with setting bits 7:3 equal to D, the pin is high for the first D PWM clocks of the cycle and low afterwards (when not extended).
- R5: A frame is 8 cycles, indexed k = 0..7. Cycle k is extended, i.e. high for D+1 PWM clocks, exactly when the 3-bit reverse of k is less than N (setting bits 2:0). With D = 0 an extended cycle holds one single-clock pulse. Over a frame the pin is high for 8*D+N PWM clocks.
- R6: A written setting takes effect only at the next frame boundary; the cycle in progress and the rest of its frame keep the previous value.
- R7: When enable bit i is 1, pin i carries the PWM waveform of channel i; when it is 0, pin i equals port latch input i.
- R8: All channels share one cycle and frame count: channels with equal settings and enables give identical pins at every clock.
- R9: A write (`wr_en` high at a rising edge) updates the addressed register at that edge; `rdata` is a combinational read of the register selected by `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rdata | output | 8 | Read data for `addr` |
| port_latch | input | 5 | Ordinary port output values, one per pin |
| pwm_pin | output | 5 | Pin values, waveform or latch per channel |

## Verification
Register writes show on `rdata` right after the capturing edge, and the latch path to a pin is combinational, so those checks sample at the next falling edge. A new setting reaches a pin only after the current frame ends, up to 256*2^(S+1) system clocks later, so duty checks first wait more than one full frame and then sum high clocks over a window of exactly one frame, which is phase-independent once the waveform is periodic. The frame-boundary check is placed by a cycle-level reference of the requirements kept in the bench, which also compares every pin at every falling edge.

// File: rtl/pwm5_brm.sv
module pwm5_brm #(
  parameter int NCH   = 5,
  parameter int AW    = 3,
  parameter int DUTYW = 5,
  parameter int BRMW  = 3,
  parameter int PSW   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic [7:0]     wdata,
  input  logic           wr_en,
  output logic [7:0]     rdata,
  input  logic [NCH-1:0] port_latch,
  output logic [NCH-1:0] pwm_pin
);
  localparam int SW       = DUTYW + BRMW;
  localparam int DIVW     = 1 << PSW;
  localparam int SEL_ADDR = NCH;
  localparam int EN_ADDR  = NCH + 1;

  logic [SW-1:0]    set_q [NCH];
  logic [SW-1:0]    act_q [NCH];
  logic [PSW-1:0]   sel_q;
  logic [NCH-1:0]   en_q;
  logic [DIVW-1:0]  div_q;
  logic [DUTYW-1:0] cyc_q;
  logic [BRMW-1:0]  frm_q;

  logic [DIVW:0]    mask;
  logic             tick, cyc_end, frame_end;
  logic [BRMW-1:0]  frm_rev;

  assign mask      = ((DIVW+1)'(2) << sel_q) - (DIVW+1)'(1);
  assign tick      = (div_q & mask[DIVW-1:0]) == mask[DIVW-1:0];
  assign cyc_end   = tick && (cyc_q == '1);
  assign frame_end = cyc_end && (frm_q == '1);

  always_comb
    for (int b = 0; b < BRMW; b++) frm_rev[b] = frm_q[BRMW-1-b];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cyc_q <= '0;
      frm_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      if (tick) cyc_q <= cyc_q + 1'b1;
      if (cyc_end) frm_q <= frm_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
      for (int i = 0; i < NCH; i++) begin
        set_q[i] <= '0;
        act_q[i] <= '0;
      end
    end else begin
      if (wr_en) begin
        for (int i = 0; i < NCH; i++)
          if (addr == AW'(i)) set_q[i] <= wdata[SW-1:0];
        if (addr == AW'(SEL_ADDR)) sel_q <= wdata[PSW-1:0];
        if (addr == AW'(EN_ADDR))  en_q  <= wdata[NCH-1:0];
      end
      if (frame_end)
        for (int i = 0; i < NCH; i++) act_q[i] <= set_q[i];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (addr == AW'(i)) rdata = 8'(set_q[i]);
    if (addr == AW'(SEL_ADDR)) rdata = 8'(sel_q);
    if (addr == AW'(EN_ADDR))  rdata = 8'(en_q);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DUTYW-1:0] duty;
    logic [BRMW-1:0]  nrep;
    logic             wave;
    assign duty = act_q[g][SW-1:BRMW];
    assign nrep = act_q[g][BRMW-1:0];
    assign wave = (cyc_q < duty) || ((cyc_q == duty) && (frm_rev < nrep));
    assign pwm_pin[g] = en_q[g] ? wave : port_latch[g];
  end
endmodule

// File: rtl/pwm5_brm_chk.sv
module pwm5_brm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [1:0] sel,
  input logic [4:0] cyc,
  input logic [2:0] frm,
  input logic [7:0] act0,
  input logic [7:0] set0,
  input logic       en0,
  input logic       pin0
);
  // R3: at the fastest rate a PWM clock never lasts a single system clock
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel == 2'd0) |=> !tick);

  // R4: the cycle position moves only on a PWM clock
  assert_cycle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cyc));

  // R5: the frame index steps by one when a cycle wraps
  assert_frame_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cyc == 5'd31) |=> (frm == $past(frm) + 3'd1));

  // R6: the active setting changes only across a frame boundary
  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cyc == 5'd31 && frm == 3'd7) |=> $stable(act0));

  // R6: at a frame boundary the staged value becomes active
  assert_active_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cyc == 5'd31 && frm == 3'd7) |=> (act0 == $past(set0)));

  // R4: an enabled channel with nonzero width is high at cycle start
  assert_cycle_start_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 && act0[7:3] != 5'd0 && cyc == 5'd0) |-> pin0);

  // R5: past the width plus the possible extension the pin is low
  assert_tail_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 && {1'b0, cyc} > {1'b0, act0[7:3]}) |-> !pin0);
endmodule

bind pwm5_brm pwm5_brm_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .tick (tick),
  .sel  (sel_q),
  .cyc  (cyc_q),
  .frm  (frm_q),
  .act0 (act_q[0]),
  .set0 (set_q[0]),
  .en0  (en_q[0]),
  .pin0 (pwm_pin[0])
);

// File: tb/sim_pwm5_brm.sv
module sim_pwm5_brm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic [7:0] rdata;
  logic [4:0] port_latch = 5'b10110;
  logic [4:0] pwm_pin;

  int checks = 0;
  int errs = 0;
  int mism = 0;
  bit mon_on = 1'b0;

  always #10 clk = ~clk;

  pwm5_brm u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
               .rdata(rdata), .port_latch(port_latch), .pwm_pin(pwm_pin));

  // Reference of the requirements at cycle level
  int       m_div, m_cyc, m_frm, m_sel;
  logic [7:0] m_reg [5];
  logic [7:0] m_act [5];
  logic [4:0] m_en;
  wire m_tick = (m_div % (2 << m_sel)) == ((2 << m_sel) - 1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div <= 0; m_cyc <= 0; m_frm <= 0; m_sel <= 0; m_en <= '0;
      for (int c = 0; c < 5; c++) begin m_reg[c] <= 8'h00; m_act[c] <= 8'h00; end
    end else begin
      m_div <= (m_div + 1) % 16;
      if (m_tick) begin
        m_cyc <= (m_cyc + 1) % 32;
        if (m_cyc == 31) begin
          m_frm <= (m_frm + 1) % 8;
          if (m_frm == 7) for (int c = 0; c < 5; c++) m_act[c] <= m_reg[c];
        end
      end
      if (wr_en) begin
        if (addr < 5) m_reg[addr] <= wdata;
        else if (addr == 5) m_sel <= int'(wdata[1:0]);
        else if (addr == 6) m_en <= wdata[4:0];
      end
    end
  end

  function automatic bit exp_pin(int c);
    int d, n, rev;
    d = int'(m_act[c][7:3]);
    n = int'(m_act[c][2:0]);
    rev = ((m_frm & 1) << 2) | (m_frm & 2) | ((m_frm >> 2) & 1);
    if (!m_en[c]) return port_latch[c];
    return (m_cyc < d) || (m_cyc == d && rev < n);
  endfunction

  always @(negedge clk)
    if (mon_on)
      for (int c = 0; c < 5; c++)
        if (pwm_pin[c] !== exp_pin(c)) mism++;

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_highs(int n, output int cnt [5]);
    for (int c = 0; c < 5; c++) cnt[c] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < 5; c++) cnt[c] += int'(pwm_pin[c]);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      check(d == 8'h00, "R1 reset register", int'(d), 0);
    end
    @(negedge clk);
    check(pwm_pin == port_latch, "R1 pins follow latch", int'(pwm_pin), int'(port_latch));
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(3'd2, 8'hA5); rd(3'd2, d);
    check(d == 8'hA5, "R9 setting write/read", int'(d), 'hA5);
    wr(3'd5, 8'hFF); rd(3'd5, d);
    check(d == 8'h03, "R2 prescale field width", int'(d), 3);
    wr(3'd6, 8'hFF); rd(3'd6, d);
    check(d == 8'h1F, "R2 enable field width", int'(d), 'h1F);
    wr(3'd7, 8'h5A); rd(3'd7, d);
    check(d == 8'h00, "R2 address 7 reads 0", int'(d), 0);
    rd(3'd2, d);
    check(d == 8'hA5, "R2 address 7 write ignored", int'(d), 'hA5);
    wr(3'd6, 8'h00); wr(3'd5, 8'h00); wr(3'd2, 8'h00);
  endtask

  task automatic t_duty;
    int cnt [5];
    wr(3'd0, 8'h83); wr(3'd1, 8'hF8); wr(3'd2, 8'h05); wr(3'd3, 8'hFF); wr(3'd4, 8'h00);
    wr(3'd6, 8'h1F);
    wait_clk(1100);
    count_highs(512, cnt);
    check(cnt[0] == 262, "R4 R5 setting 0x83 high clocks", cnt[0], 262);
    check(cnt[1] == 496, "R4 setting 0xF8 high clocks", cnt[1], 496);
    check(cnt[2] == 10, "R5 width 0 with N=5 pulses", cnt[2], 10);
    check(cnt[3] == 510, "R5 setting 0xFF high clocks", cnt[3], 510);
    check(cnt[4] == 0, "R4 setting 0 stays low", cnt[4], 0);
  endtask

  task automatic t_prescale;
    int cnt [5];
    wr(3'd5, 8'h03);
    wait_clk(8500);
    count_highs(4096, cnt);
    check(cnt[0] == 2096, "R3 divide by 16", cnt[0], 2096);
    wr(3'd5, 8'h01);
    wait_clk(2200);
    count_highs(1024, cnt);
    check(cnt[0] == 524, "R3 divide by 4", cnt[0], 524);
    wr(3'd5, 8'h00);
    wait_clk(1100);
  endtask

  task automatic t_update;
    while (!(m_frm == 1 && m_cyc == 2)) @(negedge clk);
    wr(3'd0, 8'h00);
    while (!(m_frm == 2 && m_cyc == 1)) @(negedge clk);
    check(pwm_pin[0] == 1'b1, "R6 old setting kept inside frame", int'(pwm_pin[0]), 1);
    while (!(m_frm == 0 && m_cyc == 1)) @(negedge clk);
    check(pwm_pin[0] == 1'b0, "R6 new setting after frame boundary", int'(pwm_pin[0]), 0);
  endtask

  task automatic t_enable;
    int bad = 0;
    for (int c = 0; c < 5; c++) wr(3'(c), 8'hF8);
    wr(3'd6, 8'h0A);
    wait_clk(1100);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (i == 200) port_latch = ~port_latch;
      #1;
      if ({pwm_pin[4], pwm_pin[2], pwm_pin[0]} !== {port_latch[4], port_latch[2], port_latch[0]}) bad++;
    end
    check(bad == 0, "R7 disabled pins follow latch", bad, 0);
    check(pwm_pin[1] == 1'b1 && m_cyc < 31, "R7 enabled pin carries waveform", int'(pwm_pin[1]), 1);
  endtask

  task automatic t_align;
    int bad = 0;
    for (int c = 0; c < 5; c++) wr(3'(c), 8'h5B);
    wr(3'd6, 8'h1F);
    wait_clk(1100);
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (pwm_pin != 5'b00000 && pwm_pin != 5'b11111) bad++;
    end
    check(bad == 0, "R8 equal channels stay aligned", bad, 0);
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    t_reset();
    t_regs();
    t_duty();
    t_prescale();
    t_update();
    t_enable();
    t_align();
    check(mism == 0, "R5 R6 pin matches frame schedule every clock", mism, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule